// File: doc/BRIEF.md
# Single-Level Page Translation Unit

This block turns 16-bit virtual addresses into 15-bit physical addresses through a sixteen-entry page table held in registers. Bits 15:12 of the virtual address pick one of the sixteen 4 KB pages. The entry for that page supplies a 3-bit frame number. The frame number is placed above the untouched 12-bit offset to form the physical address. Each entry also holds these bits:

- a presence bit
- a read permission bit
- a write permission bit
- a bit that marks the page as uncacheable
- a referenced bit, which hardware maintains
- a modified bit, which hardware maintains

Software fills entries through a load port. In the same cycle, software can also wipe the referenced bits of every page.

Each access is a virtual address and a write flag, qualified by a valid strobe. One clock later the unit returns one of two things:

- the physical address and the uncacheable flag, or
- a page-fault or protection-fault indication.

With every valid response the unit also reports the referenced and modified bits the entry held before the access. Software can read the status bits through these two response fields.

Top module: `pgx_translator`

## Requirements
- R1: After reset every entry is absent, with its referenced and modified bits clear. All response outputs are 0 until the first valid request has been registered.
- R2: On a successful access, rsp_paddr equals {frame of entry req_vaddr[15:12], req_vaddr[11:0]}.
- R3: An access to an entry whose presence bit is 0 raises rsp_page_fault. On that response rsp_prot_fault is 0 and rsp_paddr is 0. A page fault outranks a protection fault.
- R4: A non-faulting access sets the entry's referenced bit. rsp_was_ref shows the value the bit had before that access.
- R5: On a present page, a read without read permission raises rsp_prot_fault, and so does a write without write permission. On such a response rsp_paddr is 0.
- R6: A non-faulting write sets the entry's modified bit, and a read leaves it unchanged. rsp_was_dirty shows the value the bit had before the access.
- R7: rsp_nocache carries the entry's uncacheable bit on a successful access and is 0 on a faulting one.
- R8: Responses come one clock after the request. rsp_valid mirrors req_valid from the cycle before. When rsp_valid is 0, every other response output is 0.
- R9: A load through cfg_we writes the frame, presence, permission and uncacheable fields of entry cfg_idx, and it clears that entry's referenced and modified bits. The load outranks a status update to the same entry in the same cycle. An access in the load cycle is translated with the entry's earlier contents.
- R10: cfg_clr_ref clears the referenced bit of all sixteen entries in one cycle, overriding a set caused by an access in the same cycle. Modified bits are not affected.
- R11: A faulting access leaves the referenced and modified bits of its entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load one table entry |
| cfg_idx | input | 4 | Entry to load |
| cfg_frame | input | 3 | Frame number to load |
| cfg_present | input | 1 | Presence bit to load |
| cfg_rd_ok | input | 1 | Read permission to load |
| cfg_wr_ok | input | 1 | Write permission to load |
| cfg_nocache | input | 1 | Uncacheable bit to load |
| cfg_clr_ref | input | 1 | Clear every referenced bit |
| req_valid | input | 1 | Access request strobe |
| req_vaddr | input | 16 | Virtual address |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 15 | Physical address, 0 on fault |
| rsp_nocache | output | 1 | Uncacheable flag of the translated page |
| rsp_page_fault | output | 1 | Entry not present |
| rsp_prot_fault | output | 1 | Access kind not permitted |
| rsp_was_ref | output | 1 | Referenced bit before this access |
| rsp_was_dirty | output | 1 | Modified bit before this access |

## Verification
The bench covers same-cycle collisions between configuration and traffic. It loads an entry while that entry is being written, and it clears all referenced bits while an access sets one of them. A design with the wrong priority would report a stale referenced bit or a leftover modified bit on the next access. The bench sends a write to an absent page that also has no write permission; a unit that checks protection before presence would flag the wrong fault. It also sends writes to read-only pages, which must not mark the page modified or referenced: a unit that updates status before fault detection would report a set bit on the next access. A long pseudo-random run mixes loads, clears, reads and writes across all pages to catch a frame taken from the wrong entry or an offset that is changed.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    typedef struct packed {
        logic present;
        logic rd_ok;
        logic wr_ok;
        logic nocache;
    } perm_t;

    typedef struct packed {
        logic valid;
        logic page_fault;
        logic prot_fault;
        logic nocache;
        logic was_ref;
        logic was_dirty;
    } rsp_flags_t;

endpackage

// File: rtl/pgx_table.sv
module pgx_table
    import pgx_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int FRAME_W = 3,
    localparam int PAGES  = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [FRAME_W-1:0] cfg_frame,
    input  perm_t              cfg_perm,
    input  logic               cfg_clr_ref,
    input  logic               upd_en,
    input  logic [IDX_W-1:0]   upd_idx,
    input  logic               upd_write,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [FRAME_W-1:0] rd_frame,
    output perm_t              rd_perm,
    output logic               rd_ref,
    output logic               rd_dirty
);

    logic [FRAME_W-1:0] frame_q [PAGES];
    logic [FRAME_W-1:0] frame_d [PAGES];
    perm_t              perm_q  [PAGES];
    perm_t              perm_d  [PAGES];
    logic [PAGES-1:0]   ref_q,   ref_d;
    logic [PAGES-1:0]   dirty_q, dirty_d;

    always_comb begin
        for (int i = 0; i < PAGES; i++) begin
            frame_d[i] = frame_q[i];
            perm_d[i]  = perm_q[i];
            ref_d[i]   = ref_q[i];
            dirty_d[i] = dirty_q[i];
            // Status set from a clean access
            if (upd_en && (upd_idx == IDX_W'(i))) begin
                ref_d[i] = 1'b1;
                if (upd_write) begin
                    dirty_d[i] = 1'b1;
                end
            end
            // Global wipe of referenced bits overrides the set
            if (cfg_clr_ref) begin
                ref_d[i] = 1'b0;
            end
            // Entry load overrides everything for that entry
            if (cfg_we && (cfg_idx == IDX_W'(i))) begin
                frame_d[i] = cfg_frame;
                perm_d[i]  = cfg_perm;
                ref_d[i]   = 1'b0;
                dirty_d[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGES; i++) begin
                frame_q[i] <= '0;
                perm_q[i]  <= '0;
            end
            ref_q   <= '0;
            dirty_q <= '0;
        end else begin
            for (int i = 0; i < PAGES; i++) begin
                frame_q[i] <= frame_d[i];
                perm_q[i]  <= perm_d[i];
            end
            ref_q   <= ref_d;
            dirty_q <= dirty_d;
        end
    end

    assign rd_frame = frame_q[rd_idx];
    assign rd_perm  = perm_q[rd_idx];
    assign rd_ref   = ref_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];

    // R10
    clr_ref_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clr_ref |=> (ref_q == '0));

    // R11
    no_update_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !cfg_we) |=> ($stable(dirty_q) && ((ref_q & ~$past(ref_q)) == '0)));

endmodule

// File: rtl/pgx_check.sv
module pgx_check
    import pgx_pkg::*;
(
    input  logic  req_write,
    input  perm_t perm,
    output logic  page_fault,
    output logic  prot_fault
);

    always_comb begin
        page_fault = !perm.present;
        // Protection is only judged on present pages
        prot_fault = perm.present && (req_write ? !perm.wr_ok : !perm.rd_ok);
    end

endmodule

// File: rtl/pgx_translator.sv
module pgx_translator
    import pgx_pkg::*;
#(
    parameter int VA_W    = 16,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 3,
    localparam int IDX_W  = VA_W - OFF_W,
    localparam int PA_W   = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [FRAME_W-1:0] cfg_frame,
    input  logic               cfg_present,
    input  logic               cfg_rd_ok,
    input  logic               cfg_wr_ok,
    input  logic               cfg_nocache,
    input  logic               cfg_clr_ref,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_write,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic               rsp_nocache,
    output logic               rsp_page_fault,
    output logic               rsp_prot_fault,
    output logic               rsp_was_ref,
    output logic               rsp_was_dirty
);

    logic [IDX_W-1:0]   lk_idx;
    logic [OFF_W-1:0]   lk_off;
    logic [FRAME_W-1:0] lk_frame;
    perm_t              lk_perm;
    perm_t              cfg_perm;
    logic               lk_ref, lk_dirty;
    logic               pf, prf, clean;

    rsp_flags_t         flags_d, flags_q;
    logic [PA_W-1:0]    paddr_d, paddr_q;

    assign lk_idx   = req_vaddr[VA_W-1 -: IDX_W];
    assign lk_off   = req_vaddr[OFF_W-1:0];
    assign cfg_perm = '{present: cfg_present, rd_ok: cfg_rd_ok,
                        wr_ok: cfg_wr_ok, nocache: cfg_nocache};
    assign clean    = req_valid && !pf && !prf;

    pgx_table #(.IDX_W(IDX_W), .FRAME_W(FRAME_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_frame  (cfg_frame),
        .cfg_perm   (cfg_perm),
        .cfg_clr_ref(cfg_clr_ref),
        .upd_en     (clean),
        .upd_idx    (lk_idx),
        .upd_write  (req_write),
        .rd_idx     (lk_idx),
        .rd_frame   (lk_frame),
        .rd_perm    (lk_perm),
        .rd_ref     (lk_ref),
        .rd_dirty   (lk_dirty)
    );

    pgx_check u_check (
        .req_write (req_write),
        .perm      (lk_perm),
        .page_fault(pf),
        .prot_fault(prf)
    );

    always_comb begin
        flags_d = '0;
        paddr_d = '0;
        if (req_valid) begin
            flags_d.valid      = 1'b1;
            flags_d.page_fault = pf;
            flags_d.prot_fault = prf;
            flags_d.was_ref    = lk_ref;
            flags_d.was_dirty  = lk_dirty;
            if (clean) begin
                flags_d.nocache = lk_perm.nocache;
                paddr_d         = {lk_frame, lk_off};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            paddr_q <= '0;
        end else begin
            flags_q <= flags_d;
            paddr_q <= paddr_d;
        end
    end

    assign rsp_valid      = flags_q.valid;
    assign rsp_paddr      = paddr_q;
    assign rsp_nocache    = flags_q.nocache;
    assign rsp_page_fault = flags_q.page_fault;
    assign rsp_prot_fault = flags_q.prot_fault;
    assign rsp_was_ref    = flags_q.was_ref;
    assign rsp_was_dirty  = flags_q.was_dirty;

    // R3
    fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_page_fault |-> !rsp_prot_fault);

    // R5
    fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_page_fault || rsp_prot_fault) |-> (rsp_paddr == '0 && !rsp_nocache));

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_page_fault && !rsp_prot_fault && !rsp_was_ref
                        && !rsp_was_dirty && rsp_paddr == '0));

endmodule

// File: tb/pgx_translator_bench.sv
module pgx_translator_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 0, cfg_present = 0, cfg_rd_ok = 0, cfg_wr_ok = 0;
    logic        cfg_nocache = 0, cfg_clr_ref = 0;
    logic [3:0]  cfg_idx = '0;
    logic [2:0]  cfg_frame = '0;
    logic        req_valid = 0, req_write = 0;
    logic [15:0] req_vaddr = '0;
    logic        rsp_valid, rsp_nocache, rsp_page_fault, rsp_prot_fault;
    logic        rsp_was_ref, rsp_was_dirty;
    logic [14:0] rsp_paddr;

    int total = 0;
    int bad = 0;

    int m_frame [16];
    int m_pres [16], m_rd [16], m_wr [16], m_nc [16], m_ref [16], m_dirty [16];

    int    e_valid = 0, e_paddr = 0, e_nc = 0, e_pf = 0, e_prf = 0, e_wref = 0, e_wdirty = 0;
    string e_tag = "R1";

    always #10 clk = ~clk;

    pgx_translator u_pgx_translator (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_frame(cfg_frame),
        .cfg_present(cfg_present), .cfg_rd_ok(cfg_rd_ok), .cfg_wr_ok(cfg_wr_ok),
        .cfg_nocache(cfg_nocache), .cfg_clr_ref(cfg_clr_ref),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_nocache(rsp_nocache),
        .rsp_page_fault(rsp_page_fault), .rsp_prot_fault(rsp_prot_fault),
        .rsp_was_ref(rsp_was_ref), .rsp_was_dirty(rsp_was_dirty)
    );

    task automatic chk(input string tag, input string fld, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, fld, act, exp, $time);
        end
    endtask

    task automatic check_rsp();
        chk(e_tag, "R8 valid",     int'(rsp_valid),      e_valid);
        chk(e_tag, "R2 paddr",     int'(rsp_paddr),      e_paddr);
        chk(e_tag, "R7 nocache",   int'(rsp_nocache),    e_nc);
        chk(e_tag, "R3 pagefault", int'(rsp_page_fault), e_pf);
        chk(e_tag, "R5 protfault", int'(rsp_prot_fault), e_prf);
        chk(e_tag, "R4 was_ref",   int'(rsp_was_ref),    e_wref);
        chk(e_tag, "R6 was_dirty", int'(rsp_was_dirty),  e_wdirty);
    endtask

    // One cycle: check the previous response, drive new inputs, advance model
    task automatic cycle(input string tag,
                         input int we, input int idx, input int fr, input int pr,
                         input int rd, input int wr, input int nc, input int clr,
                         input int rv, input int va, input int rw);
        int ix, fault;
        @(negedge clk);
        check_rsp();
        cfg_we = we[0]; cfg_idx = idx[3:0]; cfg_frame = fr[2:0];
        cfg_present = pr[0]; cfg_rd_ok = rd[0]; cfg_wr_ok = wr[0];
        cfg_nocache = nc[0]; cfg_clr_ref = clr[0];
        req_valid = rv[0]; req_vaddr = va[15:0]; req_write = rw[0];
        ix = (va >> 12) & 15;
        e_tag    = tag;
        e_valid  = rv;
        e_pf     = (rv != 0 && m_pres[ix] == 0) ? 1 : 0;
        e_prf    = (rv != 0 && m_pres[ix] != 0 &&
                    ((rw != 0) ? (m_wr[ix] == 0) : (m_rd[ix] == 0))) ? 1 : 0;
        fault    = e_pf | e_prf;
        e_paddr  = (rv != 0 && fault == 0) ? ((m_frame[ix] << 12) | (va & 'hfff)) : 0;
        e_nc     = (rv != 0 && fault == 0) ? m_nc[ix] : 0;
        e_wref   = (rv != 0) ? m_ref[ix] : 0;
        e_wdirty = (rv != 0) ? m_dirty[ix] : 0;
        if (rv != 0 && fault == 0) begin
            m_ref[ix] = 1;
            if (rw != 0) m_dirty[ix] = 1;
        end
        if (clr != 0) begin
            for (int i = 0; i < 16; i++) m_ref[i] = 0;
        end
        if (we != 0) begin
            m_frame[idx] = fr; m_pres[idx] = pr; m_rd[idx] = rd;
            m_wr[idx] = wr; m_nc[idx] = nc; m_ref[idx] = 0; m_dirty[idx] = 0;
        end
    endtask

    task automatic load(input string tag, input int idx, input int fr, input int pr,
                        input int rd, input int wr, input int nc);
        cycle(tag, 1, idx, fr, pr, rd, wr, nc, 0, 0, 0, 0);
    endtask

    task automatic acc(input string tag, input int va, input int rw);
        cycle(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1, va, rw);
    endtask

    initial begin
        #4000000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lfsr;
        for (int i = 0; i < 16; i++) begin
            m_frame[i] = 0; m_pres[i] = 0; m_rd[i] = 0; m_wr[i] = 0;
            m_nc[i] = 0; m_ref[i] = 0; m_dirty[i] = 0;
        end
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        // R1: reset state of outputs
        @(negedge clk);
        chk("R1", "reset valid", int'(rsp_valid), 0);
        chk("R1", "reset paddr", int'(rsp_paddr), 0);
        chk("R1", "reset faults", int'(rsp_page_fault | rsp_prot_fault), 0);
        // R1: every page absent after reset
        for (int p = 0; p < 16; p++) acc("R1", (p << 12) | p, p & 1);
        // loads
        load("R9", 2, 5, 1, 1, 1, 0);
        load("R9", 7, 1, 1, 1, 0, 1);
        load("R9", 9, 3, 1, 0, 1, 0);
        load("R9", 15, 7, 1, 1, 1, 1);
        // R2 / R4 / R6 basic sequence
        acc("R2", 'h2abc, 0);
        acc("R4", 'h2001, 0);
        acc("R6", 'h2fff, 1);
        acc("R6", 'h2000, 1);
        // R5 write to read-only page, R11 no status change
        acc("R5", 'h7123, 1);
        acc("R11", 'h7456, 0);
        acc("R7", 'h7789, 0);
        acc("R5", 'h9010, 0);
        acc("R11", 'h9020, 1);
        // R3 absent page with write and no permission
        acc("R3", 'h4444, 1);
        acc("R3", 'h4444, 0);
        // R10 clear all referenced bits
        cycle("R10", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        acc("R10", 'h2222, 0);
        acc("R10", 'h7000, 0);
        // R10 clear in the same cycle as an access to page 15
        cycle("R10", 0, 0, 0, 0, 0, 0, 0, 1, 1, 'hf00f, 1);
        acc("R10", 'hf00f, 0);
        // R9 load during write to the same entry
        cycle("R9", 1, 2, 6, 1, 1, 0, 1, 0, 1, 'h2345, 1);
        acc("R9", 'h2345, 0);
        acc("R9", 'h2345, 1);
        // R8 idle cycle
        cycle("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 'h2345, 1);
        // mixed pseudo-random traffic
        lfsr = 'h1d3;
        for (int n = 0; n < 600; n++) begin
            int r;
            lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 'hffff;
            r = lfsr * 7 + n;
            if ((r & 'hf) == 0)
                cycle("R9", 1, (r >> 4) & 15, (r >> 8) & 7, ((r >> 11) & 3) != 0 ? 1 : 0,
                      (r >> 13) & 1, (r >> 14) & 1, (r >> 15) & 1, 0,
                      (r >> 3) & 1, lfsr, (r >> 2) & 1);
            else if ((r & 'h3f) == 1)
                cycle("R10", 0, 0, 0, 0, 0, 0, 0, 1, 1, lfsr, (r >> 5) & 1);
            else
                cycle("R2", 0, 0, 0, 0, 0, 0, 0, 0, ((r >> 9) & 7) != 0 ? 1 : 0,
                      lfsr, (r >> 4) & 1);
        end
        cycle("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        check_rsp();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule